// File: doc/BRIEF.md
# Partitioned Weight-Stationary Dot-Product Core

This block is a synthesizable functional model of a compute-in-memory style array used for low-cost event detection in a convolution pipeline. Signed 8-bit weights stay resident in the core. They are arranged as two identical arrays. Each array has eight partitions, each partition has 64 groups, and each group has sixteen lanes. One group holds the sixteen channel-direction weights of one kernel tap, for example one position of a 3x3 kernel with sixteen input channels.

A vector of sixteen unsigned 4-bit activations is broadcast to every partition of both arrays, together with a group index. The group at that index in every partition forms an inner product with the vector. All sixteen signed sums, one per partition of each array, are registered and appear together with a one-cycle result strobe on the clock edge that accepts the request.

Weights are loaded one at a time through a separate write port. The write port has priority over a compute request issued in the same cycle.

Top module: `cim_dot_core`

## Requirements
- R1: The core stores 2 arrays x 8 partitions x 64 groups x 16 lanes of two's-complement 8-bit weights. A write selects one weight by (wr_array, wr_part, wr_group, wr_lane), takes effect at the clock edge where wr_en is high, and is used by any compute accepted in a later cycle.
- R2: act_vec carries sixteen unsigned 4-bit activations, lane i in bits [4i+3:4i], and the same vector is applied to every partition of both arrays.
- R3: One act_group index selects the group at that position in every partition of both arrays. Output k = 8*array + partition is the signed 16-bit value in sum_out[16k+15:16k], equal to the sum over lanes of act[i]*w[i].
- R4: A compute accepted at a clock edge (act_valid high, wr_en low) updates sum_out and raises sum_valid for exactly one cycle at that edge. Requests on consecutive cycles give results on consecutive cycles.
- R5: When wr_en and act_valid are high in the same cycle, the write is performed, the compute is dropped, sum_valid stays low and sum_out keeps its previous value.
- R6: Whenever sum_valid is low, sum_out holds the value it had on the previous cycle.
- R7: Reset, synchronous and active high, makes every stored weight read as zero, clears sum_out and lowers sum_valid. This applies both to groups never written and to groups loaded before the reset.
- R8: Full-scale operands do not overflow. Sixteen lanes of activation 15 give -30720 with all weights -128 and 30480 with all weights 127.
- R9: Writing one lane leaves every other lane of the same group, and every other group, partition and array, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Weight write strobe |
| wr_array | input | 1 | Array select for the write |
| wr_part | input | 3 | Partition select for the write |
| wr_group | input | 6 | Group select for the write |
| wr_lane | input | 4 | Lane select for the write |
| wr_data | input | 8 | Two's-complement weight value |
| act_valid | input | 1 | Compute request strobe |
| act_group | input | 6 | Group index applied to all partitions |
| act_vec | input | 64 | Sixteen unsigned 4-bit activations |
| sum_valid | output | 1 | One-cycle result strobe |
| sum_out | output | 256 | Sixteen signed 16-bit inner products |

## Verification
The hardest situation to reach from the ports is a write and a compute that collide in the same cycle. The test must show both that the write landed and that the compute left no trace. The bench first records sum_out from a completed compute. It then drives a lane write and a compute request on the same clock edge and checks that the strobe stays low and the recorded value is unchanged. It then computes on the written group in the very next cycle, where the new weight must appear while all other lanes keep their old values. Zero-after-reset is reached both before any load and by reasserting reset after groups have been filled, so that stale storage cannot leak through.

// File: rtl/cim_pkg.sv
package cim_pkg;

    localparam int N_ARRAY = 2;
    localparam int N_PART  = 8;
    localparam int N_GROUP = 64;
    localparam int N_LANE  = 16;
    localparam int ACT_W   = 4;
    localparam int WGT_W   = 8;
    localparam int SUM_W   = 16;

    localparam int N_OUT   = N_ARRAY * N_PART;
    localparam int ARR_IW  = (N_ARRAY > 1) ? $clog2(N_ARRAY) : 1;
    localparam int PART_IW = $clog2(N_PART);
    localparam int GRP_IW  = $clog2(N_GROUP);
    localparam int LANE_IW = $clog2(N_LANE);
    localparam int VEC_W   = N_LANE * ACT_W;
    localparam int ROW_W   = N_LANE * WGT_W;
    localparam int PROD_W  = ACT_W + WGT_W + 1;
    localparam int BANK_W  = N_OUT * SUM_W;

    typedef logic [ROW_W-1:0]        row_t;
    typedef logic [VEC_W-1:0]        vec_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    typedef struct packed {
        logic               en;
        logic [ARR_IW-1:0]  arr;
        logic [PART_IW-1:0] part;
        logic [GRP_IW-1:0]  grp;
        logic [LANE_IW-1:0] lane;
        logic [WGT_W-1:0]   data;
    } wr_req_t;

    typedef struct packed {
        logic              go;
        logic [GRP_IW-1:0] grp;
        vec_t              vec;
    } cmp_req_t;

    // unsigned activation times signed weight, sign-extended to the sum width
    function automatic sum_t lane_product(input logic [ACT_W-1:0] a,
                                          input logic [WGT_W-1:0] w);
        logic signed [PROD_W-1:0] ax;
        logic signed [PROD_W-1:0] wx;
        logic signed [PROD_W-1:0] p;
        ax = {{(PROD_W-ACT_W){1'b0}}, a};
        wx = {{(PROD_W-WGT_W){w[WGT_W-1]}}, w};
        p  = ax * wx;
        return {{(SUM_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction

    function automatic sum_t dot_row(input vec_t v, input row_t r);
        sum_t acc;
        acc = '0;
        for (int l = 0; l < N_LANE; l++) begin
            acc = acc + lane_product(v[l*ACT_W +: ACT_W], r[l*WGT_W +: WGT_W]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/cim_partition.sv
module cim_partition
    import cim_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [GRP_IW-1:0]  wr_grp,
    input  logic [LANE_IW-1:0] wr_lane,
    input  logic [WGT_W-1:0]   wr_data,
    input  logic               rd_en,
    input  logic [GRP_IW-1:0]  rd_grp,
    input  vec_t               act_vec,
    output sum_t               sum_q
);

    row_t               mem [N_GROUP];
    logic [N_GROUP-1:0] live;
    row_t               wr_base;
    row_t               wr_row;
    row_t               rd_row;

    // a group never written since reset reads as all zero
    always_comb begin
        wr_base = live[wr_grp] ? mem[wr_grp] : '0;
        wr_row  = wr_base;
        for (int l = 0; l < N_LANE; l++) begin
            if (LANE_IW'(l) == wr_lane) begin
                wr_row[l*WGT_W +: WGT_W] = wr_data;
            end
        end
        rd_row = live[rd_grp] ? mem[rd_grp] : '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_grp] <= wr_row;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else if (wr_en) begin
            live[wr_grp] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else if (rd_en) begin
            sum_q <= dot_row(act_vec, rd_row);
        end
    end

endmodule

// File: rtl/cim_array.sv
module cim_array
    import cim_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [PART_IW-1:0]      wr_part,
    input  logic [GRP_IW-1:0]       wr_grp,
    input  logic [LANE_IW-1:0]      wr_lane,
    input  logic [WGT_W-1:0]        wr_data,
    input  logic                    rd_en,
    input  logic [GRP_IW-1:0]       rd_grp,
    input  vec_t                    act_vec,
    output logic [N_PART*SUM_W-1:0] sums
);

    for (genvar p = 0; p < N_PART; p++) begin : g_part
        logic part_wr;
        sum_t part_sum;

        assign part_wr = wr_en && (wr_part == PART_IW'(p));

        cim_partition i_part (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (part_wr),
            .wr_grp  (wr_grp),
            .wr_lane (wr_lane),
            .wr_data (wr_data),
            .rd_en   (rd_en),
            .rd_grp  (rd_grp),
            .act_vec (act_vec),
            .sum_q   (part_sum)
        );

        assign sums[p*SUM_W +: SUM_W] = part_sum;
    end

endmodule

// File: rtl/cim_dot_core.sv
module cim_dot_core
    import cim_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ARR_IW-1:0]          wr_array,
    input  logic [PART_IW-1:0]         wr_part,
    input  logic [GRP_IW-1:0]          wr_group,
    input  logic [LANE_IW-1:0]         wr_lane,
    input  logic [WGT_W-1:0]           wr_data,
    input  logic                       act_valid,
    input  logic [GRP_IW-1:0]          act_group,
    input  logic [VEC_W-1:0]           act_vec,
    output logic                       sum_valid,
    output logic [BANK_W-1:0]          sum_out
);

    wr_req_t  wq;
    cmp_req_t cq;
    logic     accept;

    assign wq = '{en: wr_en, arr: wr_array, part: wr_part, grp: wr_group,
                  lane: wr_lane, data: wr_data};
    assign cq = '{go: act_valid, grp: act_group, vec: act_vec};

    // the write port wins a same-cycle collision
    assign accept = cq.go && !wq.en;

    for (genvar a = 0; a < N_ARRAY; a++) begin : g_arr
        logic arr_wr;
        assign arr_wr = wq.en && (wq.arr == ARR_IW'(a));

        cim_array i_arr (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (arr_wr),
            .wr_part (wq.part),
            .wr_grp  (wq.grp),
            .wr_lane (wq.lane),
            .wr_data (wq.data),
            .rd_en   (accept),
            .rd_grp  (cq.grp),
            .act_vec (cq.vec),
            .sums    (sum_out[a*N_PART*SUM_W +: N_PART*SUM_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_valid <= 1'b0;
        end else begin
            sum_valid <= accept;
        end
    end

endmodule

// File: rtl/cim_dot_core_chk.sv
module cim_dot_core_chk
    import cim_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              act_valid,
    input logic              sum_valid,
    input logic [BANK_W-1:0] sum_out
);

    assert_accept_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (act_valid && !wr_en) |=> sum_valid);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !act_valid |=> !sum_valid);

    assert_collision_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (act_valid && wr_en) |=> !sum_valid);

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !sum_valid |-> $stable(sum_out));

    assert_reset_state_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sum_out == '0 && !sum_valid));

endmodule

bind cim_dot_core cim_dot_core_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .act_valid (act_valid),
    .sum_valid (sum_valid),
    .sum_out   (sum_out)
);

// File: tb/test_cim_dot_core.sv
module test_cim_dot_core;
    timeunit 1ns;
    timeprecision 1ps;
    import cim_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [ARR_IW-1:0]  wr_array = '0;
    logic [PART_IW-1:0] wr_part = '0;
    logic [GRP_IW-1:0]  wr_group = '0;
    logic [LANE_IW-1:0] wr_lane = '0;
    logic [WGT_W-1:0]   wr_data = '0;
    logic               act_valid = 1'b0;
    logic [GRP_IW-1:0]  act_group = '0;
    logic [VEC_W-1:0]   act_vec = '0;
    logic               sum_valid;
    logic [BANK_W-1:0]  sum_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // model storage only for the four groups the bench ever loads
    logic signed [WGT_W-1:0] mw [N_OUT][4][N_LANE];

    typedef struct packed {
        logic [GRP_IW-1:0] grp;
        logic [VEC_W-1:0]  vec;
    } stim_t;

    localparam stim_t STIM [6] = '{
        '{grp: 6'd0,  vec: 64'h0123_4567_89AB_CDEF},
        '{grp: 6'd5,  vec: 64'hFFFF_FFFF_FFFF_FFFF},
        '{grp: 6'd63, vec: 64'h1000_0000_0000_0001},
        '{grp: 6'd0,  vec: 64'hF0F0_0F0F_A5A5_5A5A},
        '{grp: 6'd5,  vec: 64'h0000_0000_0000_0000},
        '{grp: 6'd17, vec: 64'hFEDC_BA98_7654_3210}
    };

    always #2.5 clk = ~clk;

    cim_dot_core i_cim_dot_core (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_array  (wr_array),
        .wr_part   (wr_part),
        .wr_group  (wr_group),
        .wr_lane   (wr_lane),
        .wr_data   (wr_data),
        .act_valid (act_valid),
        .act_group (act_group),
        .act_vec   (act_vec),
        .sum_valid (sum_valid),
        .sum_out   (sum_out)
    );

    function automatic int slot_of(input int g);
        case (g)
            0:       return 0;
            5:       return 1;
            40:      return 2;
            63:      return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [WGT_W-1:0] pat(input int k, input int g, input int l);
        return WGT_W'((k * 29 + g * 13 + l * 7 + 3) & 255);
    endfunction

    function automatic int exp_sum(input int k, input int g, input logic [VEC_W-1:0] v);
        int s;
        int acc;
        s = slot_of(g);
        acc = 0;
        if (s >= 0) begin
            for (int l = 0; l < N_LANE; l++) begin
                acc += int'(v[l*ACT_W +: ACT_W]) * int'(mw[k][s][l]);
            end
        end
        return acc;
    endfunction

    function automatic int got_sum(input int k);
        logic signed [SUM_W-1:0] x;
        x = sum_out[k*SUM_W +: SUM_W];
        return int'(x);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < N_OUT; k++)
            for (int s = 0; s < 4; s++)
                for (int l = 0; l < N_LANE; l++)
                    mw[k][s][l] = '0;
    endtask

    task automatic set_write(input int k, input int g, input int l, input logic [WGT_W-1:0] d);
        wr_en    = 1'b1;
        wr_array = ARR_IW'(k / N_PART);
        wr_part  = PART_IW'(k % N_PART);
        wr_group = GRP_IW'(g);
        wr_lane  = LANE_IW'(l);
        wr_data  = d;
        if (slot_of(g) >= 0) mw[k][slot_of(g)][l] = d;
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic write_w(input int k, input int g, input int l, input logic [WGT_W-1:0] d);
        set_write(k, g, l, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string tag, input int g, input logic [VEC_W-1:0] v);
        check({tag, " valid"}, int'(sum_valid), 1);
        for (int k = 0; k < N_OUT; k++) begin
            check($sformatf("%s out%0d", tag, k), got_sum(k), exp_sum(k, g, v));
        end
    endtask

    task automatic compute(input string tag, input int g, input logic [VEC_W-1:0] v);
        act_valid = 1'b1;
        act_group = GRP_IW'(g);
        act_vec   = v;
        @(negedge clk);
        act_valid = 1'b0;
        check_all(tag, g, v);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (R1..R9 run): got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [BANK_W-1:0] prev;
        clear_model();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: reset state, then compute before any load
        check("R7 reset valid", int'(sum_valid), 0);
        check("R7 reset sums zero", int'(sum_out == '0), 1);
        @(negedge clk);
        compute("R7 pre-load", 0, 64'hFFFF_FFFF_FFFF_FFFF);

        // R1: load groups 0, 5 and 63 in every partition of both arrays
        for (int gi = 0; gi < 3; gi++) begin
            automatic int g = (gi == 0) ? 0 : (gi == 1) ? 5 : 63;
            for (int k = 0; k < N_OUT; k++)
                for (int l = 0; l < N_LANE; l++)
                    write_w(k, g, l, pat(k, g, l));
        end

        // R2 R3: table walk, one group broadcast to all partitions
        for (int i = 0; i < 6; i++) begin
            compute($sformatf("R3 table%0d", i), int'(STIM[i].grp), STIM[i].vec);
        end

        // R2: single-lane activation selects lane 9 only
        compute("R2 lane9", 63, 64'h0000_0000_0000_0000 | (64'h7 << (9 * ACT_W)));

        // R4: back-to-back requests, then idle
        act_valid = 1'b1;
        act_group = 6'd0;
        act_vec   = 64'h1111_2222_3333_4444;
        @(negedge clk);
        check_all("R4 first", 0, 64'h1111_2222_3333_4444);
        act_group = 6'd63;
        act_vec   = 64'h9876_5432_10FE_DCBA;
        @(negedge clk);
        act_valid = 1'b0;
        check_all("R4 second", 63, 64'h9876_5432_10FE_DCBA);
        prev = sum_out;
        @(negedge clk);
        check("R4 pulse ends", int'(sum_valid), 0);
        check("R6 hold idle", int'(sum_out == prev), 1);

        // R5: collision, write lane 2 of group 5 in array1 partition3
        compute("R5 before", 5, 64'h2345_6789_ABCD_EF01);
        prev = sum_out;
        set_write(11, 5, 2, 8'h81);
        act_valid = 1'b1;
        act_group = 6'd5;
        act_vec   = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0;
        act_valid = 1'b0;
        check("R5 dropped valid", int'(sum_valid), 0);
        check("R5 sums unchanged", int'(sum_out == prev), 1);
        // R1 R9: write visible next cycle, other lanes untouched
        compute("R9 after lane write", 5, 64'h2345_6789_ABCD_EF01);
        check("R1 written lane used", got_sum(11), exp_sum(11, 5, 64'h2345_6789_ABCD_EF01));

        // R8: full-scale operands on group 40
        for (int k = 0; k < N_OUT; k++)
            for (int l = 0; l < N_LANE; l++)
                write_w(k, 40, l, (k % 2 == 0) ? 8'h80 : 8'h7F);
        compute("R8 full scale", 40, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8 min", got_sum(0), -30720);
        check("R8 max", got_sum(15), 30480);

        // R7: reset after loading clears stored weights
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_model();
        check("R7 re-reset valid", int'(sum_valid), 0);
        check("R7 re-reset sums", int'(sum_out == '0), 1);
        compute("R7 after reload reset", 40, 64'hFFFF_FFFF_FFFF_FFFF);
        compute("R7 group0 after reset", 0, 64'h0123_4567_89AB_CDEF);

        done = 1'b1;
        finish_run();
    end

endmodule